// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Engine

A target device that lost track of a transfer can hold SDA low indefinitely, and that locks the whole bus. This engine frees the bus by pulsing SCL a limited number of times. The stuck target can then finish clocking out its byte and let SDA go. When the bus is free, the engine can also close with a STOP condition so that every target on the bus returns to idle.

Software writes a staging register that holds a pulse limit and two option bits: early termination and STOP generation. It then commits those settings into a working copy with a config-load strobe. Setting the enable bit starts a sequence with the working copy. The enable bit reads 1 while the sequence runs and clears itself when the sequence is over. A status bit then reports whether SDA was seen high.

All timing comes from a prescaled half-bit tick. The pins are open-drain pull enables, where 1 pulls the line low.

Top module: `busclr_engine`

## Requirements
- R1: After reset both pull enables are 0 and every readback is 0: config enable (address 0, bit 0), status (address 1, bit 0) and config-load (address 2, bit 0).
- R2: A write to address 0 changes only the staged fields: pulse limit in bits 23:16, STOP select in bit 2 and terminate select in bit 1. A sequence uses them only after a write of 1 to address 2, bit 0. That bit reads 1 in the cycle after the write and 0 from the next cycle on, when the working copy has been updated.
- R3: Each SCL pulse pulls SCL low until a tick, then releases it for exactly one tick period. SDA is never pulled during pulsing. SDA is sampled at the tick that ends each released phase.
- R4: With terminate select 0, exactly the pulse limit of pulses is sent. Status is the SDA level at the last sample.
- R5: With terminate select 1, pulsing ends after the first pulse whose sample sees SDA high, and status is 1. If SDA is never seen high, the full limit of pulses is sent.
- R6: When the last sample sees SDA low, status is 0 and no STOP is driven.
- R7: With STOP select 1 and a successful sequence, the engine pulls SDA while SCL is pulled. It then releases SCL for a half-bit while SDA is still held, then releases SDA. No STOP is driven when STOP select is 0.
- R8: Writing 1 to address 0, bit 0 starts a sequence. The enable bit reads 1 until the sequence ends and then clears itself. A start write while a sequence is running is ignored.
- R9: A pulse limit of 0 sends no pulses and no STOP. Status is set to the SDA level in the cycle of the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 config, 1 status, 2 config-load |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tick | input | 1 | Half-bit timing tick, one cycle wide |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The in-line properties hold on every cycle. They check that the config-load bit self-clears, that SCL moves only at a tick or a start, and that SDA is first pulled only while SCL is pulled. They also check that a STOP starts only after a success has been recorded and that the pulse count never passes the captured limit. Only the bench scenarios show the pulse counts, the early ending in terminate mode and the status values for a modelled stuck target. The same holds for the deferred effect of unloaded settings, the ignored restart and the zero-limit case.

// File: rtl/busclr_engine.sv
module busclr_engine #(
  parameter int THR_W   = 8,
  parameter int THR_LSB = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tick,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_STOP1, S_STOP2} state_t;

  state_t            state;
  logic [THR_W-1:0]  stg_thr, sh_thr, run_thr, cnt;
  logic              stg_stop, stg_term, sh_stop, sh_term, run_stop, run_term;
  logic              load_pend, status_q;

  wire wr_cfg  = reg_wr && (reg_addr == 2'd0);
  wire wr_load = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];
  wire busy    = (state != S_IDLE);
  wire start   = wr_cfg && reg_wdata[0] && !busy;
  wire last    = (run_term && sda_in) || ({1'b0, cnt} + 1'b1 == {1'b0, run_thr});

  assign scl_oe = (state == S_LOW) || (state == S_STOP1);
  assign sda_oe = (state == S_STOP1) || (state == S_STOP2);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[THR_LSB +: THR_W] = stg_thr;
        reg_rdata[2] = stg_stop;
        reg_rdata[1] = stg_term;
        reg_rdata[0] = busy;
      end
      2'd1: reg_rdata[0] = status_q;
      2'd2: reg_rdata[0] = load_pend;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_thr <= '0; stg_stop <= 1'b0; stg_term <= 1'b0;
      sh_thr <= '0;  sh_stop <= 1'b0;  sh_term <= 1'b0;
      load_pend <= 1'b0;
    end else begin
      if (wr_cfg) begin
        stg_thr  <= reg_wdata[THR_LSB +: THR_W];
        stg_stop <= reg_wdata[2];
        stg_term <= reg_wdata[1];
      end
      if (load_pend) begin
        sh_thr  <= stg_thr;
        sh_stop <= stg_stop;
        sh_term <= stg_term;
        load_pend <= 1'b0;
      end else if (wr_load) begin
        load_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0; run_thr <= '0; run_stop <= 1'b0; run_term <= 1'b0;
      status_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          run_thr  <= sh_thr;
          run_stop <= sh_stop;
          run_term <= sh_term;
          cnt      <= '0;
          if (sh_thr == '0) status_q <= sda_in;
          else              state <= S_LOW;
        end
        S_LOW: if (tick) state <= S_HIGH;
        S_HIGH: if (tick) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            status_q <= sda_in;
            state <= (sda_in && run_stop) ? S_STOP1 : S_IDLE;
          end else begin
            state <= S_LOW;
          end
        end
        S_STOP1: if (tick) state <= S_STOP2;
        S_STOP2: if (tick) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_LOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load_pend |=> !load_pend); // R2
  AST_SCL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> ($past(tick) || $past(start))); // R3
  AST_SDA_UNDER_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_oe); // R7
  AST_STOP_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> status_q); // R6
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= run_thr)); // R4
endmodule

// File: tb/busclr_engine_tb.sv
`timescale 1ns/1ps
module busclr_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tick = 1'b0;
  logic scl_oe, sda_oe, sda_in;
  logic tgt_rel;
  int   tgt_k = 0;

  int checks = 0, errors = 0;
  int pulses = 0, stops = 0, bad = 0, gap = 0;
  logic prev_scl = 1'b0, prev_sda = 1'b0;
  bit done = 0;
  logic [1:0] tdiv = 2'd0;

  always #2.5 clk = ~clk;

  assign sda_in = ~sda_oe & tgt_rel;

  busclr_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  always @(negedge clk) begin
    if (prev_scl && !scl_oe && !sda_oe) begin pulses++; gap = 0; end
    if (!scl_oe) gap++;
    if (!prev_scl && scl_oe && !sda_oe && pulses > 0 && gap != 4) bad++;
    if (!prev_sda && sda_oe && !scl_oe) bad++;
    if (prev_sda && !sda_oe && !scl_oe) stops++;
    prev_scl = scl_oe;
    prev_sda = sda_oe;
  end
  assign tgt_rel = (tgt_k == 0) || (pulses >= tgt_k);

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cfg(int thr, bit stp, bit trm, bit en);
    return {8'd0, 8'(thr), 13'd0, stp, trm, en};
  endfunction

  function automatic int keff(int k); return (k == 0) ? 1 : k; endfunction
  function automatic int exp_status(int thr, int k);
    return (thr == 0) ? ((k == 0) ? 1 : 0) : ((thr >= keff(k)) ? 1 : 0);
  endfunction
  function automatic int exp_pulses(int thr, int k, bit trm);
    if (thr == 0) return 0;
    if (trm) return (keff(k) <= thr) ? keff(k) : thr;
    return thr;
  endfunction

  task automatic load(int thr, bit stp, bit trm);
    logic [31:0] d;
    wr(2'd0, cfg(thr, stp, trm, 1'b0));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd2, d);
    check("R2 load reads 1 after write", d[0], 1);
    @(negedge clk);
    rd(2'd2, d);
    check("R2 load self-clears", d[0], 0);
  endtask

  task automatic run(int thr, int k, bit stp, bit trm, bit poke, string tag);
    logic [31:0] d;
    int es;
    tgt_k = k; pulses = 0; stops = 0; bad = 0;
    wr(2'd0, cfg(thr, stp, trm, 1'b1));
    if (thr > 0) begin
      rd(2'd0, d);
      check({tag, " R8 enable reads 1 while busy"}, d[0], 1);
    end
    if (poke) begin
      repeat (6) @(negedge clk);
      wr(2'd0, cfg(thr, stp, trm, 1'b1));
    end
    do begin @(negedge clk); rd(2'd0, d); end while (d[0]);
    repeat (3) @(negedge clk);
    es = exp_status(thr, k);
    check({tag, " R8 enable self-clears"}, d[0], 0);
    check({tag, trm ? " R5 pulses" : " R4 pulses"}, pulses, exp_pulses(thr, k, trm));
    rd(2'd1, d);
    check({tag, es ? " R4 status" : " R6 status"}, d[0], es);
    check({tag, " R7 stop count"}, stops, (thr > 0 && es == 1 && stp) ? 1 : 0);
    check({tag, " R3 pulse shape"}, bad, 0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 scl released", scl_oe, 0);
    check("R1 sda released", sda_oe, 0);
    rd(2'd0, d); check("R1 enable", d[0], 0);
    rd(2'd1, d); check("R1 status", d[0], 0);
    rd(2'd2, d); check("R1 load", d[0], 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 released after reset", {scl_oe, sda_oe}, 0);

    load(3, 1'b0, 1'b0);
    wr(2'd0, cfg(9, 1'b1, 1'b1, 1'b0));
    run(3, 20, 1'b1, 1'b0, 1'b0, "R2 staged unused");
    load(9, 1'b0, 1'b0);
    run(9, 20, 1'b0, 1'b0, 1'b0, "R2 loaded");

    load(8, 1'b1, 1'b0);
    run(8, 3, 1'b1, 1'b0, 1'b0, "R4 nonterm ok");
    load(8, 1'b1, 1'b1);
    run(8, 3, 1'b1, 1'b1, 1'b0, "R5 term early");
    load(4, 1'b1, 1'b1);
    run(4, 7, 1'b1, 1'b1, 1'b0, "R6 fail");
    load(5, 1'b0, 1'b1);
    run(5, 2, 1'b0, 1'b1, 1'b0, "R7 no stop");
    load(6, 1'b1, 1'b0);
    run(6, 2, 1'b1, 1'b0, 1'b1, "R8 restart ignored");
    load(0, 1'b1, 1'b0);
    run(0, 0, 1'b1, 1'b0, 1'b0, "R9 zero high");
    run(0, 4, 1'b1, 1'b0, 1'b0, "R9 zero low");
    load(1, 1'b1, 1'b1);
    run(1, 0, 1'b1, 1'b1, 1'b0, "R5 one pulse");
    load(255, 1'b0, 1'b1);
    run(255, 2, 1'b0, 1'b1, 1'b0, "R5 max limit");

    for (int i = 0; i < 30; i++) begin
      int thr, k; bit stp, trm;
      thr = $urandom_range(0, 10);
      k   = $urandom_range(0, 12);
      stp = 1'($urandom_range(0, 1));
      trm = 1'($urandom_range(0, 1));
      load(thr, stp, trm);
      run(thr, k, stp, trm, 1'b0, "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule